// File: doc/BRIEF.md
# Dual-Channel Parallel Converter Code Interface

This block sits between a host bus and two 12-bit converter cores. Each channel has one holding register that drives that channel's output code directly. A host writes a word on a shared 12-bit parallel bus. It uses one active-low select per channel and an active-low write strobe that both channels share. While a channel's select and the write strobe are both low, that channel's register follows the bus. If both selects are low, the same word goes into both channels in the same cycle.

The host strobes are asynchronous to the block's free-running clock. Two-flop synchronizers sample them. The data bus goes through a register chain of the same depth, so every data sample stays lined up with the strobe sample taken at the same edge. The behaviour of a transparent latch becomes a register load on every clock while a write is active. The value kept is the last one sampled before the strobe returns high. A one-cycle pulse per channel marks every cycle in which that channel's code changed.

Top module: `dual_dac_host_if`

## Requirements
- R1: Each channel has exactly one CODE_W-bit (default 12) register. Its value appears unchanged on that channel's code output.
- R2: When the write strobe `wr_n` is sampled high (1), neither register changes, whatever the selects are.
- R3: When both selects `sel_a_n` and `sel_b_n` are sampled high (1), neither register changes, whatever `wr_n` is.
- R4: With `sel_a_n`=0, `sel_b_n`=1 and `wr_n`=0, channel A loads the bus and channel B keeps its value.
- R5: With `sel_b_n`=0, `sel_a_n`=1 and `wr_n`=0, channel B loads the bus and channel A keeps its value.
- R6: With both selects at 0 and `wr_n`=0, both registers load the same bus word in the same cycle.
- R7: The inputs are level sensitive. A register loads the bus on every clock for as long as its select and `wr_n` stay low, so a bus that changes during a write is followed.
- R8: When `wr_n` returns high, the register keeps the bus word of the last sample taken while the write was active. A bus value that arrives at the same edge as the strobe's return to 1 is not loaded.
- R9: Inputs present at rising clock edge k show on the code outputs after rising edge k+2, because of the two synchronizer stages.
- R10: A synchronous active-high `rst` clears both codes to 0 and both update pulses to 0 at the next rising edge.
- R11: `upd_a` (`upd_b`) is high for exactly those cycles in which `code_a` (`code_b`) differs from its value in the previous cycle, reset excepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_n | input | 1 | Channel A select, active low, asynchronous |
| sel_b_n | input | 1 | Channel B select, active low, asynchronous |
| wr_n | input | 1 | Shared write strobe, active low, asynchronous |
| bus | input | CODE_W | Parallel data word |
| code_a | output | CODE_W | Channel A converter code |
| code_b | output | CODE_W | Channel B converter code |
| upd_a | output | 1 | One-cycle pulse: channel A code changed |
| upd_b | output | 1 | One-cycle pulse: channel B code changed |

## Verification
On every cycle, the assertions check that an idle channel holds its code, that an enabled channel loads the aligned data word, that a broadcast leaves both codes equal, that reset clears the codes, and that the update pulses match the code changes. Some behaviour shows only at the ports, across a sequence of stimuli. The two-edge latency from the pins, the correct decoding of the select and strobe combinations, and the rule that a bus word arriving with the strobe's rising edge is dropped are all checked only by the bench's scenarios, against a model that delays the inputs.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  localparam int NUM_CH = 2;

  // A channel is written when its select and the shared strobe are both low.
  function automatic logic chan_write(input logic sel_n, input logic wr_n);
    return (!sel_n) && (!wr_n);
  endfunction

  // The next code value: a loaded word when written, otherwise the held value.
  function automatic logic [31:0] next_code(input logic [31:0] held,
                                            input logic [31:0] word,
                                            input logic        wen);
    return wen ? word : held;
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/chan_reg.sv
module chan_reg #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] code,
  output logic              upd
);
  import dacif_pkg::*;

  logic [31:0]       nxt_wide;
  logic [CODE_W-1:0] nxt;
  logic              changes;

  assign nxt_wide = next_code(32'(code), 32'(din), wen);
  assign nxt      = nxt_wide[CODE_W-1:0];
  assign changes  = (nxt != code);

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      upd  <= 1'b0;
    end else begin
      code <= nxt;
      upd  <= changes;
    end
  end

  // R2/R3: an idle channel holds its code
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !wen |=> $stable(code));

  // R4/R5/R7: an enabled channel takes the aligned word
  a_r7_follow_bus: assert property (@(posedge clk) disable iff (rst)
    wen |=> code == $past(din));

  // R10: reset clears the code
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (code == '0) && !upd);

  // R11: the pulse marks a change, and its absence means no change
  a_r11_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
    upd |-> code != $past(code));
  a_r11_quiet_no_change: assert property (@(posedge clk) disable iff (rst)
    (!upd && !$past(rst)) |-> $stable(code));

endmodule

// File: rtl/dual_dac_host_if.sv
module dual_dac_host_if #(
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              wr_n,
  input  logic [CODE_W-1:0] bus,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              upd_a,
  output logic              upd_b
);
  import dacif_pkg::*;

  localparam int STB_W = NUM_CH + 1;

  logic [STB_W-1:0]  stb_raw, stb_s;
  logic [CODE_W-1:0] bus_s;
  logic              wr_n_s;
  logic [NUM_CH-1:0] sel_n_s;
  logic [NUM_CH-1:0] wen;
  logic [CODE_W-1:0] code_v [NUM_CH];
  logic [NUM_CH-1:0] upd_v;

  assign stb_raw = {wr_n, sel_b_n, sel_a_n};

  // Strobes idle high through reset
  sync_chain #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL({STB_W{1'b1}})) u_stb_sync (
    .clk(clk), .rst(rst), .d(stb_raw), .q(stb_s)
  );

  // Data delayed by the same depth, so it stays aligned with the strobe sample
  sync_chain #(.W(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL({CODE_W{1'b0}})) u_bus_align (
    .clk(clk), .rst(rst), .d(bus), .q(bus_s)
  );

  assign wr_n_s  = stb_s[STB_W-1];
  assign sel_n_s = stb_s[NUM_CH-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wen[c] = chan_write(sel_n_s[c], wr_n_s);
    chan_reg #(.CODE_W(CODE_W)) u_reg (
      .clk(clk), .rst(rst), .wen(wen[c]), .din(bus_s),
      .code(code_v[c]), .upd(upd_v[c])
    );
  end

  assign code_a = code_v[0];
  assign code_b = code_v[1];
  assign upd_a  = upd_v[0];
  assign upd_b  = upd_v[1];

  // R6: a broadcast leaves both channels equal
  a_r6_broadcast_equal: assert property (@(posedge clk) disable iff (rst)
    (wen[0] && wen[1]) |=> code_a == code_b);

  // R2: strobe high means no channel is enabled
  a_r2_strobe_gates: assert property (@(posedge clk) disable iff (rst)
    wr_n_s |-> (wen == '0));

  // R3: both selects high means no channel is enabled
  a_r3_selects_gate: assert property (@(posedge clk) disable iff (rst)
    (&sel_n_s) |-> (wen == '0));

endmodule

// File: tb/dual_dac_host_if_test.sv
module dual_dac_host_if_test;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_a_n = 1'b1, sel_b_n = 1'b1, wr_n = 1'b1;
  logic [W-1:0] bus = '0;
  logic [W-1:0] code_a, code_b;
  logic upd_a, upd_b;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  dual_dac_host_if uut (
    .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .wr_n(wr_n),
    .bus(bus), .code_a(code_a), .code_b(code_b), .upd_a(upd_a), .upd_b(upd_b)
  );

  // vector packing: {sel_a_n, sel_b_n, wr_n, bus}
  localparam logic [W+2:0] IDLE = {3'b111, {W{1'b0}}};
  logic [W+2:0] h1 = IDLE, h2 = IDLE, h3 = IDLE;
  logic [W-1:0] ea = '0, eb = '0;

  function automatic logic [W-1:0] model_next(logic [W-1:0] held, logic sn, logic wn, logic [W-1:0] d);
    if (sn == 1'b0 && wn == 1'b0) return d;
    return held;
  endfunction

  function automatic string case_tag(logic [W+2:0] v);
    if (v[W]) return "R2";
    if (v[W+2] && v[W+1]) return "R3";
    if (!v[W+2] && !v[W+1]) return "R6";
    if (!v[W+2]) return "R4";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // One step: check the effect of the vector driven three negedges ago (R9), then drive v
  task automatic step(logic sa, logic sb, logic w, logic [W-1:0] d);
    logic [W-1:0] na, nb;
    string t;
    @(negedge clk);
    t  = case_tag(h3);
    na = model_next(ea, h3[W+2], h3[W], h3[W-1:0]);
    nb = model_next(eb, h3[W+1], h3[W], h3[W-1:0]);
    chk({t, "/R1/R9 code_a"}, code_a, na);
    chk({t, "/R1/R9 code_b"}, code_b, nb);
    chk("R11 upd_a", {{(W-1){1'b0}}, upd_a}, {{(W-1){1'b0}}, na != ea});
    chk("R11 upd_b", {{(W-1){1'b0}}, upd_b}, {{(W-1){1'b0}}, nb != eb});
    ea = na; eb = nb;
    h3 = h2; h2 = h1; h1 = {sa, sb, w, d};
    sel_a_n = sa; sel_b_n = sb; wr_n = w; bus = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sel_a_n = 1'b1; sel_b_n = 1'b1; wr_n = 1'b1; bus = '0;
    @(negedge clk);
    chk("R10 code_a", code_a, '0);
    chk("R10 code_b", code_b, '0);
    chk("R10 upd", {{(W-2){1'b0}}, upd_a, upd_b}, '0);
    @(negedge clk);
    rst = 1'b0;
    h1 = IDLE; h2 = IDLE; h3 = IDLE; ea = '0; eb = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected < 50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    h1 = IDLE; h2 = IDLE; h3 = IDLE;
    chk("R10 code_a after reset", code_a, '0);
    chk("R10 code_b after reset", code_b, '0);

    // R4: A only
    step(0, 1, 0, 12'h5A3);
    step(1, 1, 1, 12'h000);
    // R5: B only
    step(1, 0, 0, 12'h0C7);
    step(1, 1, 1, 12'hFFF);
    // R2: strobe high with both selects low, no load
    step(0, 0, 1, 12'h111);
    // R3: both selects high with strobe low, no load
    step(1, 1, 0, 12'h222);
    // R6: broadcast
    step(0, 0, 0, 12'hABC);
    step(1, 1, 1, 12'h000);
    // R7: level sensitive, the register follows a moving bus
    step(0, 1, 0, 12'h001);
    step(0, 1, 0, 12'h002);
    step(0, 1, 0, 12'h004);
    // R8: strobe rises together with new data; last active word kept
    step(0, 1, 1, 12'h7E7);
    step(0, 1, 1, 12'h3C3);
    // R11: rewriting the same word must not pulse
    step(1, 0, 0, 12'h0C7);
    step(1, 0, 0, 12'h0C7);
    step(1, 1, 1, 12'h000);
    repeat (4) step(1, 1, 1, 12'h000);
    chk("R8 code_a held", code_a, 12'h004);
    chk("R2/R3 code_b held", code_b, 12'h0C7);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0] & r[3], r[1] & r[3], r[2], W'($urandom));
    end

    // R10: reset in mid-run
    step(0, 0, 0, 12'h9D2);
    repeat (3) step(1, 1, 1, 12'h000);
    do_reset();
    for (int i = 0; i < 500; i++) begin
      logic [2:0] r;
      r = 3'($urandom);
      step(r[0], r[1], r[2], W'($urandom));
    end
    repeat (4) step(1, 1, 1, 12'h000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule